// File: doc/BRIEF.md
# Binary to Base-31 Packer

This block moves data between plain binary and elements of the prime field GF(31). It has three independent streaming channels, each with a valid/ready handshake on its input and on its output. The first channel takes an unsigned binary word and emits its base-31 digits one per cycle, least significant first. At the default width of 64 bits that is always exactly 13 digits. A key payload of 128, 192 or 256 bits therefore becomes two, three or four words, which is 26, 39 or 52 digits.

The second channel stores three field elements in one 16-bit word. Each element gets a 5-bit field and the spare top bit is zero. The packing is injective but does not use every code, so it never needs a wide multiply. The third channel undoes that packing. The divide-by-31 step that feeds the digit channel uses a multiply by a fixed reciprocal and a shift. The remainder is then the word minus 31 times the quotient.

A caller that is forming a message for a field-based scheme uses the digit channel to turn hash or key material into field elements. It uses the pack and unpack channels to store and reload those elements compactly.

Top module: `b31_codec`

## Requirements
- R1: After reset, every output valid and the pack error flag are low, and every input ready is high.
- R2: For each accepted word the digit channel emits exactly K digits, where K is the smallest count with 31^K ≥ 2^WORD_W (13 at 64 bits, 3 at 10 bits). Each digit is in 0..30, and the digit at position i (0 first) is floor(word / 31^i) mod 31. The sum of digit_i·31^i equals the word.
- R3: The first digit is valid in the cycle after the word is accepted. With output ready held high, one digit follows per cycle. The last-digit flag is high on digit K−1 only, and input ready returns high in the cycle after that digit is taken.
- R4: While a conversion is in progress, the digit channel's input ready is low and any word offered on its input has no effect on the digits produced.
- R5: While a digit is valid and output ready is low, the digit and the last-digit flag hold their values.
- R6: A triple (d0, d1, d2) with every element ≤ 30 is packed into d0 + 32·d1 + 1024·d2: d0 in bits 4:0, d1 in bits 9:5, d2 in bits 14:10, and bit 15 zero. The word is valid in the cycle after acceptance.
- R7: A triple with any element equal to 31 produces no output word. Instead, the error flag is high for exactly the one cycle after acceptance.
- R8: An unpacked word gives element 0 from bits 4:0, element 1 from bits 9:5 and element 2 from bits 14:10, one cycle after acceptance. Bit 15 does not affect the result.
- R9: The pack and unpack outputs hold while they are valid and output ready is low. Input ready is low exactly when the output is valid and not being taken, so a new item can be accepted in the same cycle the old one leaves.
- R10: Packing a valid triple and unpacking the resulting word gives back the same triple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp_in_valid | input | 1 | Binary word offered to digit channel |
| sp_in_ready | output | 1 | Digit channel can take a word |
| sp_in_word | input | WORD_W | Unsigned binary word to split |
| sp_out_valid | output | 1 | A digit is presented |
| sp_out_ready | input | 1 | Consumer takes the digit |
| sp_out_digit | output | 5 | Current base-31 digit |
| sp_out_last | output | 1 | Current digit is the most significant one |
| pk_in_valid | input | 1 | Triple offered to packer |
| pk_in_ready | output | 1 | Packer can take a triple |
| pk_in_digits | input | 3·5 | Elements, element g in bits 5g+4:5g |
| pk_out_valid | output | 1 | Packed word presented |
| pk_out_ready | input | 1 | Consumer takes the packed word |
| pk_out_word | output | 16 | Packed word |
| pk_out_err | output | 1 | One-cycle pulse: rejected triple |
| un_in_valid | input | 1 | Packed word offered to unpacker |
| un_in_ready | output | 1 | Unpacker can take a word |
| un_in_word | input | 16 | Packed word to unpack |
| un_out_valid | output | 1 | Unpacked triple presented |
| un_out_ready | input | 1 | Consumer takes the triple |
| un_out_digits | output | 3·5 | Elements, element g in bits 5g+4:5g |

## Verification
The bench builds two copies of the block. One uses the default 64-bit word, so it covers the 13-digit case, the all-ones word and the powers of 31 near the top of the range. The other uses a 10-bit word, which has three digits per word, so all 1024 inputs of the digit channel can be swept and each one rebuilt from its digits. In the default build the bench also sweeps the packer over all 32768 5-bit triples, including every triple that holds the value 31, and sweeps the unpacker over all 65536 words.

// File: rtl/b31_pkg.sv
package b31_pkg;

    localparam int unsigned MOD     = 31;
    localparam int unsigned DIG_W   = 5;
    localparam int unsigned DIG_MAX = MOD - 1;

    typedef logic [DIG_W-1:0] digit_t;

    // smallest k with MOD^k >= 2^w (valid for w up to about 120)
    function automatic int unsigned digits_for_width(input int unsigned w);
        logic [127:0] lim;
        logic [127:0] pw;
        int unsigned  k;
        lim = 128'd1 << w;
        pw  = 128'd1;
        k   = 0;
        for (int i = 0; i < 40; i++) begin
            if (pw < lim) begin
                pw = pw * 128'(MOD);
                k  = k + 1;
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/b31_div31.sv
// Combinational divide by 31 using a reciprocal multiply and shift.
module b31_div31
    import b31_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] quot_o,
    output digit_t       rem_o
);
    localparam int unsigned SH    = W + DIG_W;
    localparam int unsigned PW    = 2 * W + 1;
    localparam logic [SH:0] ONE_S = {1'b1, {SH{1'b0}}};
    localparam logic [SH:0] MAG_F = ONE_S / (SH + 1)'(MOD) + (SH + 1)'(1);
    localparam logic [W:0]  MAGIC = MAG_F[W:0];

    logic [PW-1:0] prod;

    always_comb begin
        prod   = PW'(x_i) * PW'(MAGIC);
        quot_o = W'(prod >> SH);
        // x - 31q == x + q (mod 32), and the true remainder is below 32
        rem_o  = x_i[DIG_W-1:0] + quot_o[DIG_W-1:0];
    end

endmodule

// File: rtl/b31_split.sv
// Serial radix-31 digit extraction, least significant digit first.
module b31_split
    import b31_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_word,
    output logic         out_valid,
    input  logic         out_ready,
    output digit_t       out_digit,
    output logic         out_last
);
    localparam int unsigned NDIG  = digits_for_width(W);
    localparam int unsigned CNT_W = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NDIG - 1);

    typedef struct packed {
        logic             busy;
        logic [W-1:0]     rem;
        logic [CNT_W-1:0] idx;
    } split_st_t;

    split_st_t st_d, st_q;
    logic [W-1:0] quot;
    digit_t       digit;
    logic         at_last;

    b31_div31 #(.W(W)) u_div (
        .x_i    (st_q.rem),
        .quot_o (quot),
        .rem_o  (digit)
    );

    always_comb begin
        st_d      = st_q;
        at_last   = (st_q.idx == LAST_IDX);
        in_ready  = !st_q.busy;
        out_valid = st_q.busy;
        out_digit = digit;
        out_last  = st_q.busy && at_last;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy = 1'b1;
                st_d.rem  = in_word;
                st_d.idx  = '0;
            end
        end else if (out_ready) begin
            st_d.rem = quot;
            if (at_last) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/b31_pack.sv
// Packs DPW field elements into one word, 5 bits each, top bit zero.
module b31_pack
    import b31_pkg::*;
#(
    parameter int unsigned DPW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DPW*DIG_W-1:0]   in_digits,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [DPW*DIG_W:0]     out_word,
    output logic                   out_err
);
    localparam int unsigned PACK_W = DPW * DIG_W + 1;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [PACK_W-1:0] word;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [DPW-1:0] bad_vec;

    for (genvar g = 0; g < DPW; g++) begin : g_range
        assign bad_vec[g] = (in_digits[g*DIG_W +: DIG_W] > DIG_W'(DIG_MAX));
    end

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        in_ready  = !st_q.valid || out_ready;
        if (out_ready) st_d.valid = 1'b0;
        if (in_valid && in_ready) begin
            if (|bad_vec) begin
                st_d.err = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.word  = {1'b0, in_digits};
            end
        end
        out_valid = st_q.valid;
        out_word  = st_q.word;
        out_err   = st_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/b31_unpack.sv
// Splits a packed word into DPW 5-bit fields.
module b31_unpack
    import b31_pkg::*;
#(
    parameter int unsigned DPW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DPW*DIG_W-1:0] in_fields,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DPW*DIG_W-1:0] out_digits
);
    typedef struct packed {
        logic                 valid;
        logic [DPW*DIG_W-1:0] fields;
    } unpack_st_t;

    unpack_st_t st_d, st_q;
    logic [DPW*DIG_W-1:0] split_f;

    for (genvar g = 0; g < DPW; g++) begin : g_field
        assign split_f[g*DIG_W +: DIG_W] = in_fields[g*DIG_W +: DIG_W];
    end

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.valid || out_ready;
        if (out_ready) st_d.valid = 1'b0;
        if (in_valid && in_ready) begin
            st_d.valid  = 1'b1;
            st_d.fields = split_f;
        end
        out_valid  = st_q.valid;
        out_digits = st_q.fields;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/b31_codec.sv
module b31_codec
    import b31_pkg::*;
#(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned DPW    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sp_in_valid,
    output logic                  sp_in_ready,
    input  logic [WORD_W-1:0]     sp_in_word,
    output logic                  sp_out_valid,
    input  logic                  sp_out_ready,
    output logic [4:0]            sp_out_digit,
    output logic                  sp_out_last,
    input  logic                  pk_in_valid,
    output logic                  pk_in_ready,
    input  logic [DPW*5-1:0]      pk_in_digits,
    output logic                  pk_out_valid,
    input  logic                  pk_out_ready,
    output logic [DPW*5:0]        pk_out_word,
    output logic                  pk_out_err,
    input  logic                  un_in_valid,
    output logic                  un_in_ready,
    input  logic [DPW*5:0]        un_in_word,
    output logic                  un_out_valid,
    input  logic                  un_out_ready,
    output logic [DPW*5-1:0]      un_out_digits
);
    localparam int unsigned FIELD_W = DPW * DIG_W;

    b31_split #(.W(WORD_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (sp_in_valid),
        .in_ready  (sp_in_ready),
        .in_word   (sp_in_word),
        .out_valid (sp_out_valid),
        .out_ready (sp_out_ready),
        .out_digit (sp_out_digit),
        .out_last  (sp_out_last)
    );

    b31_pack #(.DPW(DPW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pk_in_valid),
        .in_ready  (pk_in_ready),
        .in_digits (pk_in_digits),
        .out_valid (pk_out_valid),
        .out_ready (pk_out_ready),
        .out_word  (pk_out_word),
        .out_err   (pk_out_err)
    );

    // the spare top bit of a packed word carries no element
    b31_unpack #(.DPW(DPW)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (un_in_valid),
        .in_ready   (un_in_ready),
        .in_fields  (un_in_word[FIELD_W-1:0]),
        .out_valid  (un_out_valid),
        .out_ready  (un_out_ready),
        .out_digits (un_out_digits)
    );

endmodule

// File: rtl/b31_codec_chk.sv
module b31_codec_chk #(
    parameter int unsigned DPW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sp_in_ready,
    input logic           sp_out_valid,
    input logic           sp_out_ready,
    input logic [4:0]     sp_out_digit,
    input logic           sp_out_last,
    input logic           pk_out_valid,
    input logic           pk_out_ready,
    input logic [DPW*5:0] pk_out_word,
    input logic           pk_out_err,
    input logic           un_out_valid,
    input logic           un_out_ready,
    input logic [DPW*5-1:0] un_out_digits
);

    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out_valid |-> (sp_out_digit <= 5'd30));

    // R4
    split_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_out_valid |-> !sp_in_ready);

    // R3
    split_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_out_valid && sp_out_ready && sp_out_last) |=> sp_in_ready);

    // R5
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_out_valid && !sp_out_ready) |=>
            (sp_out_valid && $stable(sp_out_digit) && $stable(sp_out_last)));

    // R6
    pack_topbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_out_valid |-> !pk_out_word[DPW*5]);

    // R7
    pack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_out_err |-> !pk_out_valid);

    // R9
    pack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_out_valid && !pk_out_ready) |=> (pk_out_valid && $stable(pk_out_word)));

    // R9
    unpack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (un_out_valid && !un_out_ready) |=> (un_out_valid && $stable(un_out_digits)));

endmodule

bind b31_codec b31_codec_chk #(.DPW(DPW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sp_in_ready   (sp_in_ready),
    .sp_out_valid  (sp_out_valid),
    .sp_out_ready  (sp_out_ready),
    .sp_out_digit  (sp_out_digit),
    .sp_out_last   (sp_out_last),
    .pk_out_valid  (pk_out_valid),
    .pk_out_ready  (pk_out_ready),
    .pk_out_word   (pk_out_word),
    .pk_out_err    (pk_out_err),
    .un_out_valid  (un_out_valid),
    .un_out_ready  (un_out_ready),
    .un_out_digits (un_out_digits)
);

// File: tb/tb_b31_codec.sv
module tb_b31_codec;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // default build, 64-bit words
    logic        sp_in_valid = 0, sp_out_ready = 1;
    logic [63:0] sp_in_word = '0;
    logic        sp_in_ready, sp_out_valid, sp_out_last;
    logic [4:0]  sp_out_digit;
    logic        pk_in_valid = 0, pk_out_ready = 1;
    logic [14:0] pk_in_digits = '0;
    logic        pk_in_ready, pk_out_valid, pk_out_err;
    logic [15:0] pk_out_word;
    logic        un_in_valid = 0, un_out_ready = 1;
    logic [15:0] un_in_word = '0;
    logic        un_in_ready, un_out_valid;
    logic [14:0] un_out_digits;

    // small build, 10-bit words
    logic        s_in_valid = 0;
    logic [9:0]  s_in_word = '0;
    logic        s_in_ready, s_out_valid, s_out_last;
    logic [4:0]  s_out_digit;
    logic        s_pk_in_ready, s_pk_out_valid, s_pk_out_err;
    logic [15:0] s_pk_out_word;
    logic        s_un_in_ready, s_un_out_valid;
    logic [14:0] s_un_out_digits;

    b31_codec #(.WORD_W(64), .DPW(3)) dut (
        .clk(clk), .rst_n(rst_n),
        .sp_in_valid(sp_in_valid), .sp_in_ready(sp_in_ready), .sp_in_word(sp_in_word),
        .sp_out_valid(sp_out_valid), .sp_out_ready(sp_out_ready),
        .sp_out_digit(sp_out_digit), .sp_out_last(sp_out_last),
        .pk_in_valid(pk_in_valid), .pk_in_ready(pk_in_ready), .pk_in_digits(pk_in_digits),
        .pk_out_valid(pk_out_valid), .pk_out_ready(pk_out_ready),
        .pk_out_word(pk_out_word), .pk_out_err(pk_out_err),
        .un_in_valid(un_in_valid), .un_in_ready(un_in_ready), .un_in_word(un_in_word),
        .un_out_valid(un_out_valid), .un_out_ready(un_out_ready),
        .un_out_digits(un_out_digits)
    );

    b31_codec #(.WORD_W(10), .DPW(3)) dut_small (
        .clk(clk), .rst_n(rst_n),
        .sp_in_valid(s_in_valid), .sp_in_ready(s_in_ready), .sp_in_word(s_in_word),
        .sp_out_valid(s_out_valid), .sp_out_ready(1'b1),
        .sp_out_digit(s_out_digit), .sp_out_last(s_out_last),
        .pk_in_valid(1'b0), .pk_in_ready(s_pk_in_ready), .pk_in_digits(15'd0),
        .pk_out_valid(s_pk_out_valid), .pk_out_ready(1'b1),
        .pk_out_word(s_pk_out_word), .pk_out_err(s_pk_out_err),
        .un_in_valid(1'b0), .un_in_ready(s_un_in_ready), .un_in_word(16'd0),
        .un_out_valid(s_un_out_valid), .un_out_ready(1'b1),
        .un_out_digits(s_un_out_digits)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic split64(input logic [63:0] w, input bit stall);
        logic [63:0] rem, recon, pw;
        logic [4:0]  held;
        @(negedge clk);
        chk(sp_in_ready, "R3 idle ready", 64'(sp_in_ready), 64'd1);
        sp_in_valid = 1; sp_in_word = w;
        @(negedge clk);
        sp_in_valid = 0;
        rem = w; recon = '0; pw = 64'd1;
        for (int i = 0; i < 13; i++) begin
            if (stall && i == 1) begin
                sp_out_ready = 0; sp_in_valid = 1; sp_in_word = ~w;
                held = sp_out_digit;
                repeat (3) begin
                    @(negedge clk);
                    chk(sp_out_valid && sp_out_digit == held, "R5 hold",
                        64'(sp_out_digit), 64'(held));
                    chk(!sp_in_ready, "R4 busy ready", 64'(sp_in_ready), 64'd0);
                end
                sp_in_valid = 0; sp_out_ready = 1;
            end
            chk(sp_out_valid && sp_out_digit == 5'(rem % 64'd31), "R2 digit",
                64'(sp_out_digit), rem % 64'd31);
            chk(sp_out_last == (i == 12), "R3 last flag",
                64'(sp_out_last), 64'(i == 12));
            recon = recon + 64'(sp_out_digit) * pw;
            pw = pw * 64'd31;
            rem = rem / 64'd31;
            @(negedge clk);
        end
        chk(!sp_out_valid && sp_in_ready, "R3 back to idle",
            64'({sp_out_valid, sp_in_ready}), 64'b01);
        chk(recon == w, "R2 rebuild", recon, w);
    endtask

    task automatic split10(input logic [9:0] w);
        logic [63:0] rem, recon, pw;
        @(negedge clk);
        s_in_valid = 1; s_in_word = w;
        @(negedge clk);
        s_in_valid = 0;
        rem = 64'(w); recon = '0; pw = 64'd1;
        for (int i = 0; i < 3; i++) begin
            chk(s_out_valid && s_out_digit == 5'(rem % 64'd31) && s_out_last == (i == 2),
                "R2 small digit", 64'({s_out_last, s_out_digit}),
                64'({(i == 2), 5'(rem % 64'd31)}));
            recon = recon + 64'(s_out_digit) * pw;
            pw = pw * 64'd31;
            rem = rem / 64'd31;
            @(negedge clk);
        end
        chk(recon == 64'(w) && s_in_ready, "R2 small rebuild", recon, 64'(w));
    endtask

    task automatic round_trip(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
        logic [15:0] w;
        @(negedge clk);
        pk_in_valid = 1; pk_in_digits = {c, b, a};
        @(negedge clk);
        pk_in_valid = 0;
        w = pk_out_word;
        un_in_valid = 1; un_in_word = w;
        @(negedge clk);
        un_in_valid = 0;
        chk(un_out_valid && un_out_digits == {c, b, a}, "R10 round trip",
            64'(un_out_digits), 64'({c, b, a}));
    endtask

    initial begin
        logic [63:0] edge_w [9];
        edge_w[0] = 64'd0;
        edge_w[1] = 64'd1;
        edge_w[2] = 64'd30;
        edge_w[3] = 64'd31;
        edge_w[4] = 64'd961;
        edge_w[5] = '1;
        edge_w[6] = 64'h8000_0000_0000_0000;
        edge_w[7] = 64'd787662783788549761;   // 31^12
        edge_w[8] = 64'd787662783788549760;

        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(!sp_out_valid && !pk_out_valid && !un_out_valid && !pk_out_err, "R1 valids",
            64'({sp_out_valid, pk_out_valid, un_out_valid, pk_out_err}), 64'd0);
        chk(sp_in_ready && pk_in_ready && un_in_ready && s_in_ready, "R1 readies",
            64'({sp_in_ready, pk_in_ready, un_in_ready, s_in_ready}), 64'hf);

        for (int i = 0; i < 9; i++) split64(edge_w[i], i == 5);
        for (int i = 0; i < 250; i++) split64({$urandom, $urandom}, (i % 16) == 3);

        for (int v = 0; v < 1024; v++) split10(10'(v));

        // packer sweep over every 5-bit triple, one per cycle
        for (int v = 0; v <= 32768; v++) begin
            @(negedge clk);
            if (v > 0) begin
                int p, d0, d1, d2;
                p = v - 1;
                d0 = p % 32; d1 = (p / 32) % 32; d2 = (p / 1024) % 32;
                if (d0 == 31 || d1 == 31 || d2 == 31)
                    chk(pk_out_err && !pk_out_valid, "R7 reject",
                        64'({pk_out_err, pk_out_valid}), 64'b10);
                else
                    chk(pk_out_valid && !pk_out_err &&
                        pk_out_word == 16'(d0 + 32 * d1 + 1024 * d2), "R6 pack",
                        64'(pk_out_word), 64'(d0 + 32 * d1 + 1024 * d2));
            end
            pk_in_valid = (v < 32768);
            pk_in_digits = 15'(v);
        end
        pk_in_valid = 0;

        // unpacker sweep over every 16-bit word
        for (int v = 0; v <= 65536; v++) begin
            @(negedge clk);
            if (v > 0) begin
                int p;
                p = v - 1;
                chk(un_out_valid && un_out_digits ==
                    {5'((p / 1024) % 32), 5'((p / 32) % 32), 5'(p % 32)}, "R8 unpack",
                    64'(un_out_digits), 64'(p % 32768));
            end
            un_in_valid = (v < 65536);
            un_in_word = 16'(v);
        end
        un_in_valid = 0;

        // R9 backpressure on packer and unpacker
        @(negedge clk);
        pk_out_ready = 0; pk_in_valid = 1; pk_in_digits = {5'd7, 5'd8, 5'd9};
        un_out_ready = 0; un_in_valid = 1; un_in_word = 16'h1234;
        @(negedge clk);
        pk_in_digits = {5'd1, 5'd2, 5'd3};
        un_in_word = 16'h0abc;
        repeat (2) begin
            @(negedge clk);
            chk(pk_out_valid && !pk_in_ready && pk_out_word == 16'(9 + 32 * 8 + 1024 * 7),
                "R9 pack hold", 64'(pk_out_word), 64'(9 + 32 * 8 + 1024 * 7));
            chk(un_out_valid && !un_in_ready && un_out_digits == 15'h1234,
                "R9 unpack hold", 64'(un_out_digits), 64'h1234);
        end
        pk_out_ready = 1; un_out_ready = 1;
        @(negedge clk);
        pk_in_valid = 0; un_in_valid = 0;
        chk(pk_out_valid && pk_out_word == 16'(3 + 32 * 2 + 1024 * 1), "R9 pack next",
            64'(pk_out_word), 64'(3 + 32 * 2 + 1024 * 1));
        chk(un_out_valid && un_out_digits == 15'h0abc, "R9 unpack next",
            64'(un_out_digits), 64'h0abc);
        @(negedge clk);
        chk(!pk_out_valid && !un_out_valid, "R9 drained",
            64'({pk_out_valid, un_out_valid}), 64'd0);

        for (int i = 0; i < 200; i++)
            round_trip(5'($urandom % 31), 5'($urandom % 31), 5'($urandom % 31));
        round_trip(5'd30, 5'd30, 5'd30);
        round_trip(5'd0, 5'd0, 5'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R3 actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule